// File: doc/BRIEF.md
# Line-End Pulse Generator

This block produces the line-end strobe of a display panel interface. It runs on the controller clock and watches two inputs. The first is the panel pixel clock, which is resynchronised and edge-detected in the controller domain. The second is a last-pixel flag from the horizontal timing logic. When a rising panel-clock edge coincides with the last-pixel flag, a programmable count of controller cycles starts. When the count expires, the line-end output goes high and stays high for one panel-clock period.

A single 32-bit control register holds an enable bit and a 7-bit delay field. The delay field holds the wanted number of controller cycles minus one. Clearing the enable forces the output low at once and abandons any count in progress.

Top module: `lep_gen`

## Requirements
- R1: After reset, the control register reads 0x00000000 and `le_out` is low.
- R2: Writing `cfg_wdata` with `cfg_wr` high sets the enable from bit 16 and the delay D from bits 6:0. All other bits are ignored on write and read back as zero, so writing 0xFFFFFFFF reads back 0x0001007F.
- R3: An event is taken only when a rising edge of `pclk_in` is detected while `last_pix` is high. `pclk_in` passes two synchroniser flops and then an edge flop, so a rise first sampled at edge e is detected at edge e+2. Falling edges, rises with `last_pix` low, and `last_pix` high with no rise do nothing.
- R4: For an event detected at edge t with delay field D, `le_out` goes high after edge t+D+1, which is D+1 controller cycles later.
- R5: Once high, `le_out` falls after the next detected rising edge of `pclk_in`, whether or not `last_pix` is high, so the pulse lasts one panel-clock period.
- R6: An event that arrives while a count is running reloads the counter with the current D, and the count starts again.
- R7: A write that clears the enable drives `le_out` low from the edge of that write. While disabled, counts are abandoned and events are ignored.
- R8: A delay value written during a count does not change that count. It applies from the next event.
- R9: An event detected on the same edge that a count would expire restarts the count, and no pulse is raised on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_wr | input | 1 | control register write strobe |
| cfg_wdata | input | 32 | control register write data |
| cfg_rdata | output | 32 | control register read value |
| pclk_in | input | 1 | panel pixel clock, asynchronous to `clk` |
| last_pix | input | 1 | last pixel of the line, synchronous to `clk` |
| le_out | output | 1 | line-end pulse |

## Verification
The assertions assume three things about the inputs:
- `last_pix` is synchronous to `clk`.
- `pclk_in` stays at each level for at least two controller cycles, so every panel edge is seen exactly once.
- Register writes last a single cycle.

The stimulus respects these limits. It drives all inputs on the falling edge of `clk`, holds each panel-clock phase for four or more cycles, and asserts `last_pix` for a whole panel period, so the delayed edge detection always finds it stable. Delays are chosen so that some counts finish inside a line, some are restarted, and one lands exactly on the next event.

// File: rtl/lep_pkg.sv
package lep_pkg;
   // counter state of the delay engine
   typedef enum logic {
      LEP_IDLE = 1'b0,
      LEP_RUN  = 1'b1
   } lep_state_e;

   // mask of a field of given lsb and width inside a word
   function automatic logic [63:0] lep_field_mask(input int lsb, input int width);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/lep_cfg_reg.sv
module lep_cfg_reg #(
   parameter int REG_W   = 32,
   parameter int ENA_BIT = 16,
   parameter int DLY_LSB = 0,
   parameter int DLY_W   = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             ena,
   output logic [DLY_W-1:0] dly
);
   localparam int DLY_MSB = DLY_LSB + DLY_W - 1;

   if (ENA_BIT >= REG_W) begin : g_bad_ena
      $error("lep_cfg_reg: enable bit outside register");
   end
   if (DLY_MSB >= REG_W) begin : g_bad_dly
      $error("lep_cfg_reg: delay field outside register");
   end
   if (ENA_BIT >= DLY_LSB && ENA_BIT <= DLY_MSB) begin : g_overlap
      $error("lep_cfg_reg: enable bit overlaps delay field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena <= 1'b0;
         dly <= '0;
      end else if (wr_en) begin
         ena <= wdata[ENA_BIT];
         dly <= wdata[DLY_LSB +: DLY_W];
      end
   end

   always_comb begin
      rdata                   = '0;
      rdata[ENA_BIT]          = ena;
      rdata[DLY_LSB +: DLY_W] = dly;
   end
endmodule

// File: rtl/lep_edge_sync.sv
module lep_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pclk_in,
   output logic rise
);
   logic lvl_s;
   logic lvl_prev;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 8) begin : g_bad_sync
      $error("lep_edge_sync: SYNC_STAGES must be 0..8");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl_s = pclk_in;
   end else begin : g_chain
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh <= '0;
         end else begin
            sh[0] <= pclk_in;
            for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
         end
      end
      assign lvl_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= lvl_s;
   end

   assign rise = lvl_s & ~lvl_prev;
endmodule

// File: rtl/lep_delay_ctr.sv
module lep_delay_ctr
   import lep_pkg::*;
#(
   parameter int DLY_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ena,
   input  logic             load,
   input  logic [DLY_W-1:0] ld_val,
   output logic             fire,
   output logic             run,
   output logic [DLY_W-1:0] cnt
);
   lep_state_e state;

   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_w
      $error("lep_delay_ctr: DLY_W must be 1..16");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= LEP_IDLE;
         cnt   <= '0;
      end else if (!ena) begin
         state <= LEP_IDLE;
         cnt   <= '0;
      end else if (load) begin
         state <= LEP_RUN;
         cnt   <= ld_val;
      end else if (state == LEP_RUN) begin
         if (cnt == '0) state <= LEP_IDLE;
         else           cnt   <= cnt - 1'b1;
      end
   end

   assign run  = (state == LEP_RUN);
   assign fire = ena && !load && run && (cnt == '0);
endmodule

// File: rtl/lep_pulse.sv
module lep_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic ena,
   input  logic fire,
   input  logic rise,
   output logic le_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    le_q <= 1'b0;
      else if (!ena) le_q <= 1'b0;
      else if (fire) le_q <= 1'b1;
      else if (rise) le_q <= 1'b0;
   end
endmodule

// File: rtl/lep_gen.sv
module lep_gen #(
   parameter int REG_W       = 32,
   parameter int ENA_BIT     = 16,
   parameter int DLY_LSB     = 0,
   parameter int DLY_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             pclk_in,
   input  logic             last_pix,
   output logic             le_out
);
   logic             ena;
   logic [DLY_W-1:0] dly;
   logic             rise;
   logic             evt;
   logic             fire;
   logic             run;
   logic [DLY_W-1:0] cnt;
   logic             le_q;

   lep_cfg_reg #(
      .REG_W(REG_W), .ENA_BIT(ENA_BIT), .DLY_LSB(DLY_LSB), .DLY_W(DLY_W)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .ena(ena), .dly(dly)
   );

   lep_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pclk_in(pclk_in), .rise(rise)
   );

   assign evt = rise & last_pix & ena;

   lep_delay_ctr #(.DLY_W(DLY_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ena(ena), .load(evt), .ld_val(dly),
      .fire(fire), .run(run), .cnt(cnt)
   );

   lep_pulse u_pls (
      .clk(clk), .rst_n(rst_n), .ena(ena), .fire(fire), .rise(rise), .le_q(le_q)
   );

   assign le_out = le_q & ena;
endmodule

// File: rtl/lep_gen_chk.sv
module lep_gen_chk #(
   parameter int REG_W   = 32,
   parameter int ENA_BIT = 16,
   parameter int DLY_LSB = 0,
   parameter int DLY_W   = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [REG_W-1:0] cfg_wdata,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             le_out,
   input logic             ena,
   input logic [DLY_W-1:0] dly,
   input logic             rise,
   input logic             evt,
   input logic             fire,
   input logic             run,
   input logic [DLY_W-1:0] cnt,
   input logic             le_q
);
   localparam logic [63:0] USED64 = lep_pkg::lep_field_mask(DLY_LSB, DLY_W)
                                  | lep_pkg::lep_field_mask(ENA_BIT, 1);
   localparam logic [REG_W-1:0] RSV = ~USED64[REG_W-1:0];

   // R2
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & RSV) == '0);

   // R7
   dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_wdata[ENA_BIT]) |=> !le_out);

   // R4
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (run && cnt == $past(dly)));

   // R8
   dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ena && run && !evt && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R5
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (le_q && rise && !fire) |=> !le_q);

   // R9
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt == '0 && evt) |=> !le_q);

   // R4
   rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(le_q) |-> ($past(run) && $past(cnt) == '0));
endmodule

bind lep_gen lep_gen_chk #(
   .REG_W(REG_W), .ENA_BIT(ENA_BIT), .DLY_LSB(DLY_LSB), .DLY_W(DLY_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
   .cfg_rdata(cfg_rdata), .le_out(le_out), .ena(ena), .dly(dly),
   .rise(rise), .evt(evt), .fire(fire), .run(run), .cnt(cnt), .le_q(le_q)
);

// File: tb/sim_lep_gen.sv
module sim_lep_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        pclk_in = 1'b0;
   logic        last_pix = 1'b0;
   logic        le_out;

   int    total = 0;
   int    bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference state
   bit      m_sh0, m_sh1, m_prev, m_run, m_le, m_en;
   int      m_cnt, m_dly;

   lep_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pclk_in(pclk_in), .last_pix(last_pix), .le_out(le_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      bit rs, ev, fr;
      if (!rst_n) begin
         m_sh0 = 0; m_sh1 = 0; m_prev = 0; m_run = 0; m_le = 0; m_en = 0;
         m_cnt = 0; m_dly = 0;
      end else begin
         rs = m_sh1 && !m_prev;
         ev = rs && last_pix && m_en;
         fr = 0;
         if (!m_en) begin
            m_run = 0; m_cnt = 0; m_le = 0;
         end else begin
            if (ev) begin
               m_run = 1; m_cnt = m_dly;
            end else if (m_run) begin
               if (m_cnt == 0) begin m_run = 0; fr = 1; end
               else m_cnt = m_cnt - 1;
            end
            if (fr) m_le = 1;
            else if (rs) m_le = 0;
         end
         if (cfg_wr) begin
            m_en  = cfg_wdata[16];
            m_dly = int'(cfg_wdata[6:0]);
         end
         m_prev = m_sh1; m_sh1 = m_sh0; m_sh0 = pclk_in;
      end
   end

   always @(negedge clk) begin
      logic [31:0] exp_rd;
      bit          exp_le;
      if (!done) begin
         exp_rd = {15'b0, m_en, 9'b0, 7'(m_dly)};
         exp_le = m_le && m_en;
         total++;
         if (le_out !== exp_le) begin
            bad++;
            $display("FAIL %s le_out actual=%0b expected=%0b t=%0t", cur_req, le_out, exp_le, $time);
         end
         total++;
         if (cfg_rdata !== exp_rd) begin
            bad++;
            $display("FAIL %s cfg_rdata actual=%08h expected=%08h t=%0t", cur_req, cfg_rdata, exp_rd, $time);
         end
      end
   end

   task automatic write_cfg(input logic [31:0] v);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wdata = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_pix(input int n, input int half, input bit last_all);
      for (int p = 0; p < n; p++) begin
         last_pix = last_all || (p == n - 1);
         pclk_in = 1'b1;
         repeat (half) @(negedge clk);
         pclk_in = 1'b0;
         repeat (half) @(negedge clk);
      end
      last_pix = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired in %s", cur_req);
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      idle(4);
      rst_n = 1'b1;
      idle(3);
      cur_req = "R2";              // reserved bits dropped: expect 0001007F
      write_cfg(32'hFFFF_FFFF);
      idle(2);
      write_cfg(32'h0000_0000);
      idle(2);
      cur_req = "R3";              // enable, D=2, lines of 6 pixels
      write_cfg(32'h0001_0002);
      run_pix(6, 4, 0);
      run_pix(6, 4, 0);
      idle(6);
      last_pix = 1'b1; idle(10); last_pix = 1'b0;   // flag without edge
      cur_req = "R4";
      write_cfg(32'h0001_0000);    // D=0
      run_pix(4, 4, 0);
      write_cfg(32'h0001_0005);    // D=5
      run_pix(5, 5, 0);
      run_pix(3, 5, 0);
      cur_req = "R5";
      write_cfg(32'h0001_0001);
      run_pix(3, 6, 0);
      run_pix(3, 6, 0);
      idle(20);
      cur_req = "R6";              // D=20 with repeated events
      write_cfg(32'h0001_0014);
      run_pix(3, 4, 1);
      run_pix(4, 8, 0);
      idle(40);
      cur_req = "R8";              // change D during a count
      write_cfg(32'h0001_001E);
      run_pix(1, 4, 1);
      write_cfg(32'h0001_0003);
      idle(40);
      run_pix(1, 4, 1);
      idle(12);
      cur_req = "R7";
      write_cfg(32'h0001_001E);
      run_pix(1, 4, 1);
      idle(5);
      write_cfg(32'h0000_001E);    // abort count
      idle(40);
      write_cfg(32'h0001_0000);
      run_pix(1, 8, 1);            // pulse is high now
      write_cfg(32'h0000_0000);
      idle(3);
      run_pix(4, 4, 1);            // ignored while disabled
      write_cfg(32'h0001_0000);
      idle(8);
      cur_req = "R9";              // D=7 with an event every 8 cycles
      write_cfg(32'h0001_0007);
      run_pix(6, 4, 1);
      write_cfg(32'h0001_0006);
      run_pix(4, 4, 1);
      idle(20);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule